// File: doc/BRIEF.md
# External Sensor Buffer Allocator and Byte Swapper

This block collects bytes that an auxiliary bus master reads from up to four external targets and places them in one shared 24-entry byte buffer. Each target slot is configured with:

- an enable,
- a 4-bit read length,
- the target register address where its read begins,
- a swap bit,
- a grouping bit.

The slot's base entry in the buffer is the sum of the lengths of the enabled slots with lower numbers, so slot 0 starts at entry 0.

The master itself lies outside the block. It delivers a byte stream: each byte arrives with a valid strobe, a slot tag and an offset within that slot's read. The block turns slot and offset into a buffer entry and writes the byte there in one clock.

When the swap bit is set, the two bytes of an address pair exchange positions. The grouping bit decides whether pairs begin on even or odd target addresses.

Allocation is frozen while any slot stays enabled. It is recomputed only when every slot is disabled or a master reset is pulsed. A two-state machine controls this:

- ALLOC_OPEN: the bases follow the configuration on every clock.
- ALLOC_HELD: the bases are frozen.

The machine has two transitions:

- OPEN_TO_HELD, taken when any slot is enabled and no master reset is present.
- HELD_TO_OPEN, taken when all slots are disabled or a master reset arrives.

Top module: `ext_sens_alloc`

## Requirements
- R1: Slot bases are assigned in slot order 0..3. Slot 0 has base 0, and each base is the sum of the lengths of the enabled slots below it. Slot i's base appears on `base_idx[i*7 +: 7]`.
- R2: A byte with `wr_valid`=1, an enabled slot and an offset below that slot's length is written to entry base+relative position at the next rising clock edge. Entry e of the buffer appears on `buf_data[e*8 +: 8]`.
- R3: A byte whose computed entry is 24 or more is dropped, and no entry changes.
- R4: Nothing is written when `wr_valid` is 0, when the tagged slot is disabled, or when the offset is not below the slot's length.
- R5: The target address of a byte is its start address plus its offset. With the grouping bit at 0, addresses 2k and 2k+1 form a pair. With it at 1, addresses 2k+1 and 2k+2 form a pair. With swap set, the two bytes of a pair exchange relative positions. With swap clear, relative position equals offset.
- R6: A pair member whose partner lies outside the read range keeps its position. For example, start 1, length 4, grouping 0 and swap on place offsets 0,1,2,3 at relative entries 0,2,1,3.
- R7: While at least one slot is enabled and no master reset is present, the bases hold their values even if enables or lengths change (state ALLOC_HELD).
- R8: When all slots are disabled, all bases become 0 at the next edge. The first edge that sees an enable again captures new bases from the configuration present at that edge.
- R9: A one-cycle `mst_rst` pulse recomputes the bases from the current configuration at that edge.
- R10: Buffer entries keep their contents through any reallocation. Only `rst_n` low clears entries and bases to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mst_rst | input | 1 | Master reset pulse; forces allocation recompute |
| slot_en | input | 4 | Per-slot enable |
| slot_len | input | 16 | Per-slot read length, 4 bits per slot |
| slot_start | input | 32 | Per-slot start register address, 8 bits per slot |
| slot_swap | input | 4 | Per-slot pair swap enable |
| slot_grp | input | 4 | Per-slot grouping: 0 pairs even-first, 1 pairs odd-first |
| wr_valid | input | 1 | Incoming byte strobe |
| wr_slot | input | 2 | Slot tag of incoming byte |
| wr_ofs | input | 4 | Offset of byte within its slot's read |
| wr_data | input | 8 | Incoming byte |
| base_idx | output | 28 | Current base entry per slot, 7 bits per slot |
| buf_data | output | 192 | Buffer contents, 8 bits per entry |

## Verification
The assertions assume that the inputs are held at zero while `rst_n` is low, and that `mst_rst` is a single-cycle pulse. The freeze property relies on the previous cycle's enables and master reset having been seen after reset. The bench drives all inputs only on falling edges, keeps every input at zero through reset, and raises `mst_rst` for exactly one cycle. The stimulus includes writes tagged for disabled slots, offsets past a slot's length, and indices past the buffer end. These writes exercise the properties that require the buffer to stay unchanged.

// File: rtl/ext_alloc_pkg.sv
package ext_alloc_pkg;
    typedef enum logic {
        ALLOC_OPEN = 1'b0,
        ALLOC_HELD = 1'b1
    } alloc_state_t;
endpackage

// File: rtl/ext_alloc_base.sv
// Prefix-sum of enabled slot lengths, registered when load is high.
module ext_alloc_base #(
    parameter int NUM_SLOTS = 4,
    parameter int LEN_W     = 4,
    parameter int IDX_W     = 7
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load,
    input  logic [NUM_SLOTS-1:0]       en,
    input  logic [NUM_SLOTS*LEN_W-1:0] len,
    output logic [NUM_SLOTS*IDX_W-1:0] base
);
    logic [IDX_W-1:0] psum [NUM_SLOTS+1];

    assign psum[0] = '0;

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_sum
        assign psum[i+1] = psum[i]
                         + (en[i] ? IDX_W'(len[i*LEN_W +: LEN_W]) : '0);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base[i*IDX_W +: IDX_W] <= '0;
            end else if (load) begin
                base[i*IDX_W +: IDX_W] <= psum[i];
            end
        end
    end
endmodule

// File: rtl/ext_alloc_map.sv
// Maps a tagged byte to a buffer entry, applying pair swap.
module ext_alloc_map #(
    parameter int NUM_SLOTS = 4,
    parameter int LEN_W     = 4,
    parameter int ADDR_W    = 8,
    parameter int IDX_W     = 7,
    parameter int BUF_DEPTH = 24,
    localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
    input  logic                        valid,
    input  logic [SLOT_W-1:0]           slot,
    input  logic [LEN_W-1:0]            ofs,
    input  logic [NUM_SLOTS-1:0]        en,
    input  logic [NUM_SLOTS*LEN_W-1:0]  len,
    input  logic [NUM_SLOTS*ADDR_W-1:0] start,
    input  logic [NUM_SLOTS-1:0]        swap,
    input  logic [NUM_SLOTS-1:0]        grp,
    input  logic [NUM_SLOTS*IDX_W-1:0]  base,
    output logic                        hit,
    output logic [IDX_W-1:0]            idx
);
    logic [LEN_W:0]   s_len;
    logic [LEN_W:0]   ofs_x;
    logic [LEN_W:0]   rel;
    logic             addr_lsb;
    logic             lead;

    always_comb begin
        s_len    = {1'b0, len[slot*LEN_W +: LEN_W]};
        ofs_x    = {1'b0, ofs};
        addr_lsb = start[slot*ADDR_W] ^ ofs[0];
        // leading member of a pair: even address for grouping 0, odd for 1
        lead     = (addr_lsb == grp[slot]);
        rel      = ofs_x;
        if (swap[slot]) begin
            if (lead && ((ofs_x + 1'b1) < s_len)) begin
                rel = ofs_x + 1'b1;
            end else if (!lead && (ofs != '0)) begin
                rel = ofs_x - 1'b1;
            end
        end
        idx = base[slot*IDX_W +: IDX_W] + IDX_W'(rel);
        hit = valid && en[slot] && (ofs_x < s_len)
              && (idx < IDX_W'(BUF_DEPTH));
    end
endmodule

// File: rtl/ext_alloc_store.sv
// Byte buffer; one entry written per clock.
module ext_alloc_store #(
    parameter int BUF_DEPTH = 24,
    parameter int DATA_W    = 8,
    parameter int IDX_W     = 7
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we,
    input  logic [IDX_W-1:0]            widx,
    input  logic [DATA_W-1:0]           wdata,
    output logic [BUF_DEPTH*DATA_W-1:0] entries
);
    for (genvar e = 0; e < BUF_DEPTH; e++) begin : g_ent
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                entries[e*DATA_W +: DATA_W] <= '0;
            end else if (we && (widx == IDX_W'(e))) begin
                entries[e*DATA_W +: DATA_W] <= wdata;
            end
        end
    end
endmodule

// File: rtl/ext_sens_alloc.sv
module ext_sens_alloc
    import ext_alloc_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int LEN_W     = 4,
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 8,
    parameter int BUF_DEPTH = 24,
    localparam int SLOT_W   = $clog2(NUM_SLOTS),
    localparam int IDX_W    = $clog2(NUM_SLOTS*((1 << LEN_W) - 1) + 1) + 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        mst_rst,
    input  logic [NUM_SLOTS-1:0]        slot_en,
    input  logic [NUM_SLOTS*LEN_W-1:0]  slot_len,
    input  logic [NUM_SLOTS*ADDR_W-1:0] slot_start,
    input  logic [NUM_SLOTS-1:0]        slot_swap,
    input  logic [NUM_SLOTS-1:0]        slot_grp,
    input  logic                        wr_valid,
    input  logic [SLOT_W-1:0]           wr_slot,
    input  logic [LEN_W-1:0]            wr_ofs,
    input  logic [DATA_W-1:0]           wr_data,
    output logic [NUM_SLOTS*IDX_W-1:0]  base_idx,
    output logic [BUF_DEPTH*DATA_W-1:0] buf_data
);
    alloc_state_t state_q, state_d;
    logic         any_en;
    logic         load_bases;
    logic         map_hit;
    logic [IDX_W-1:0] map_idx;

    assign any_en = |slot_en;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ALLOC_OPEN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d    = state_q;
        load_bases = 1'b0;
        unique case (state_q)
            ALLOC_OPEN: begin
                load_bases = 1'b1;
                if (any_en && !mst_rst) begin
                    state_d = ALLOC_HELD;     // OPEN_TO_HELD
                end
            end
            ALLOC_HELD: begin
                if (!any_en || mst_rst) begin
                    load_bases = 1'b1;
                    state_d    = ALLOC_OPEN;  // HELD_TO_OPEN
                end
            end
            default: begin
                state_d = ALLOC_OPEN;
            end
        endcase
    end

    ext_alloc_base #(
        .NUM_SLOTS (NUM_SLOTS),
        .LEN_W     (LEN_W),
        .IDX_W     (IDX_W)
    ) u_base (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load_bases),
        .en    (slot_en),
        .len   (slot_len),
        .base  (base_idx)
    );

    ext_alloc_map #(
        .NUM_SLOTS (NUM_SLOTS),
        .LEN_W     (LEN_W),
        .ADDR_W    (ADDR_W),
        .IDX_W     (IDX_W),
        .BUF_DEPTH (BUF_DEPTH)
    ) u_map (
        .valid (wr_valid),
        .slot  (wr_slot),
        .ofs   (wr_ofs),
        .en    (slot_en),
        .len   (slot_len),
        .start (slot_start),
        .swap  (slot_swap),
        .grp   (slot_grp),
        .base  (base_idx),
        .hit   (map_hit),
        .idx   (map_idx)
    );

    ext_alloc_store #(
        .BUF_DEPTH (BUF_DEPTH),
        .DATA_W    (DATA_W),
        .IDX_W     (IDX_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (map_hit),
        .widx    (map_idx),
        .wdata   (wr_data),
        .entries (buf_data)
    );
endmodule

// File: rtl/ext_sens_alloc_chk.sv
module ext_sens_alloc_chk #(
    parameter int NUM_SLOTS = 4,
    parameter int DATA_W    = 8,
    parameter int BUF_DEPTH = 24,
    parameter int IDX_W     = 7,
    parameter int SLOT_W    = 2
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        mst_rst,
    input logic [NUM_SLOTS-1:0]        slot_en,
    input logic                        wr_valid,
    input logic [SLOT_W-1:0]           wr_slot,
    input logic [NUM_SLOTS*IDX_W-1:0]  base_idx,
    input logic [BUF_DEPTH*DATA_W-1:0] buf_data
);
    logic armed;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
        end else begin
            armed <= 1'b1;
        end
    end

    assert_alloc_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(|slot_en && !mst_rst) && (|slot_en) && !mst_rst)
        |=> $stable(base_idx));

    assert_all_off_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(|slot_en) |=> (base_idx == '0));

    assert_idle_no_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_valid |=> $stable(buf_data));

    assert_disabled_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !slot_en[wr_slot]) |=> $stable(buf_data));

    for (genvar i = 0; i < NUM_SLOTS - 1; i++) begin : g_ord
        assert_base_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
            base_idx[i*IDX_W +: IDX_W] <= base_idx[(i+1)*IDX_W +: IDX_W]);
    end
endmodule

bind ext_sens_alloc ext_sens_alloc_chk #(
    .NUM_SLOTS (NUM_SLOTS),
    .DATA_W    (DATA_W),
    .BUF_DEPTH (BUF_DEPTH),
    .IDX_W     (IDX_W),
    .SLOT_W    (SLOT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mst_rst  (mst_rst),
    .slot_en  (slot_en),
    .wr_valid (wr_valid),
    .wr_slot  (wr_slot),
    .base_idx (base_idx),
    .buf_data (buf_data)
);

// File: tb/tb_ext_sens_alloc.sv
module tb_ext_sens_alloc;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         mst_rst = 1'b0;
    logic [3:0]   slot_en = '0;
    logic [15:0]  slot_len = '0;
    logic [31:0]  slot_start = '0;
    logic [3:0]   slot_swap = '0;
    logic [3:0]   slot_grp = '0;
    logic         wr_valid = 1'b0;
    logic [1:0]   wr_slot = '0;
    logic [3:0]   wr_ofs = '0;
    logic [7:0]   wr_data = '0;
    logic [27:0]  base_idx;
    logic [191:0] buf_data;

    int checks = 0;
    int fails = 0;
    logic [7:0] model [24];

    always #10 clk = ~clk;

    ext_sens_alloc dut (
        .clk(clk), .rst_n(rst_n), .mst_rst(mst_rst),
        .slot_en(slot_en), .slot_len(slot_len), .slot_start(slot_start),
        .slot_swap(slot_swap), .slot_grp(slot_grp),
        .wr_valid(wr_valid), .wr_slot(wr_slot), .wr_ofs(wr_ofs),
        .wr_data(wr_data), .base_idx(base_idx), .buf_data(buf_data)
    );

    // {slot, ofs, data, expected entry (FF = dropped), requirement number}
    localparam int NVEC = 15;
    localparam logic [31:0] VEC [NVEC] = '{
        {4'd0, 4'd0,  8'hA0, 8'd0,   8'd6},  // R6 lone byte at start
        {4'd0, 4'd1,  8'hA1, 8'd2,   8'd5},  // R5 swap, grouping 0
        {4'd0, 4'd2,  8'hA2, 8'd1,   8'd5},
        {4'd0, 4'd3,  8'hA3, 8'd3,   8'd6},  // R6 lone byte at end
        {4'd1, 4'd0,  8'hB0, 8'd4,   8'd6},  // R6 grouping 1, lone first
        {4'd1, 4'd1,  8'hB1, 8'd6,   8'd5},
        {4'd1, 4'd2,  8'hB2, 8'd5,   8'd5},
        {4'd2, 4'd0,  8'hC0, 8'd7,   8'd2},  // R2 no swap
        {4'd2, 4'd14, 8'hCE, 8'd21,  8'd2},
        {4'd3, 4'd0,  8'hD0, 8'd23,  8'd5},
        {4'd3, 4'd1,  8'hD1, 8'd22,  8'd5},
        {4'd3, 4'd2,  8'hD2, 8'hFF,  8'd3},  // R3 entry 25
        {4'd3, 4'd3,  8'hD3, 8'hFF,  8'd3},  // R3 entry 24
        {4'd3, 4'd4,  8'hD4, 8'hFF,  8'd3},  // R3 entry 26
        {4'd0, 4'd4,  8'hE4, 8'hFF,  8'd4}   // R4 offset beyond length
    };

    task automatic chk_buf(input string req);
        for (int e = 0; e < 24; e++) begin
            checks++;
            if (buf_data[e*8 +: 8] !== model[e]) begin
                fails++;
                $display("FAIL %s entry %0d actual=%02h expected=%02h",
                         req, e, buf_data[e*8 +: 8], model[e]);
            end
        end
    endtask

    task automatic chk_base(input string req, input int s, input int exp);
        checks++;
        if (base_idx[s*7 +: 7] !== 7'(exp)) begin
            fails++;
            $display("FAIL %s base%0d actual=%0d expected=%0d",
                     req, s, base_idx[s*7 +: 7], exp);
        end
    endtask

    task automatic put(input int s, input int o, input logic [7:0] d);
        @(negedge clk);
        wr_valid = 1'b1; wr_slot = 2'(s); wr_ofs = 4'(o); wr_data = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int e = 0; e < 24; e++) model[e] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_buf("R10 reset");
        for (int s = 0; s < 4; s++) chk_base("R10 reset", s, 0);

        // slot0: start 1 len 4 grp0 swap; slot1: start 10h len 3 grp1 swap
        // slot2: start 40h len 15 no swap; slot3: start 20h len 5 grp0 swap
        slot_start = {8'h20, 8'h40, 8'h10, 8'h01};
        slot_len   = {4'd5, 4'd15, 4'd3, 4'd4};
        slot_grp   = 4'b0010;
        slot_swap  = 4'b1011;
        slot_en    = 4'b1111;
        @(negedge clk);
        chk_base("R1", 0, 0);  chk_base("R1", 1, 4);
        chk_base("R1", 2, 7);  chk_base("R1", 3, 22);

        for (int v = 0; v < NVEC; v++) begin
            put(int'(VEC[v][31:28]), int'(VEC[v][27:24]), VEC[v][23:16]);
            if (VEC[v][15:8] != 8'hFF) model[VEC[v][15:8]] = VEC[v][23:16];
            chk_buf($sformatf("R%0d vec%0d", VEC[v][7:0], v));
        end

        // R4: valid low with busy data
        @(negedge clk);
        wr_slot = 2'd0; wr_ofs = 4'd0; wr_data = 8'h55;
        @(negedge clk);
        chk_buf("R4 idle");

        // R7: disable slot1 and change a length; bases frozen
        slot_en = 4'b1101;
        slot_len[3:0] = 4'd9;
        @(negedge clk);
        chk_base("R7", 1, 4); chk_base("R7", 2, 7); chk_base("R7", 3, 22);
        put(1, 0, 8'h77);  // R4 disabled slot
        chk_buf("R4 disabled slot");
        put(2, 0, 8'hC1);
        model[7] = 8'hC1;
        chk_buf("R7 frozen base write");

        // R8: all disabled -> bases zero, contents kept (R10)
        slot_en = 4'b0000;
        @(negedge clk);
        for (int s = 0; s < 4; s++) chk_base("R8 all off", s, 0);
        chk_buf("R10 kept");

        // re-enable slot0 len2 and slot3 len3, no swap on slot3
        slot_len  = {4'd3, 4'd15, 4'd3, 4'd2};
        slot_swap = 4'b0011;
        slot_en   = 4'b1001;
        @(negedge clk);
        chk_base("R8 recapture", 3, 2);
        put(3, 0, 8'h3C);
        model[2] = 8'h3C;
        chk_buf("R10 realloc");

        // R9: change length while held, then pulse master reset
        slot_len[3:0] = 4'd6;
        @(negedge clk);
        chk_base("R7 held", 3, 2);
        mst_rst = 1'b1;
        @(negedge clk);
        mst_rst = 1'b0;
        chk_base("R9", 3, 6);
        @(negedge clk);
        chk_base("R9 after", 3, 6);
        chk_buf("R10 after mst_rst");

        // R10: rst_n clears everything
        rst_n = 1'b0;
        slot_en = '0; slot_len = '0; slot_start = '0;
        slot_swap = '0; slot_grp = '0; wr_data = '0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int e = 0; e < 24; e++) model[e] = 8'h00;
        chk_buf("R10 rst_n");
        for (int s = 0; s < 4; s++) chk_base("R10 rst_n", s, 0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule